// File: doc/BRIEF.md
# Quad-Channel Receive Clock Selector

This block chooses the timing source for each of the four receive output clock pins of a four-lane serial receiver. It also chooses the timing source for the four per-channel output registers. Clocks are modelled as single-cycle character strobes in one fabric clock domain. The reference clock arrives as `ref_stb`, and the four recovered character clocks arrive as `rec_stb`. The block produces registered strobes, output enables and a source code for each pin, so no clock is ever switched through a glitch-prone multiplexer.

A three-level clock mode picks the scheme:
- **Reference mode:** everything runs from the reference.
- **Per-channel mode:** each pin follows its own lane.
- **Selected mode:** the B and D pins become static select levels that pick one or two recovered lanes. The set of lanes they pick from depends on whether the receiver runs independent, dual-bonded or quad-bonded.

A rate select halves every recovered strobe by toggle division. Illegal settings raise a configuration-error flag and fall back to per-channel clocking. In quad-bonded operation the block reports the bonding master channel.

Top module: `rxclk_sel_top`

## Requirements
- R1: With `clk_mode`=0 (reference) and a legal configuration, pins A and C carry source code 4 (reference) with `pin_oe`=4'b0101. Pins B and D carry code 7 (off) and are disabled. All four `reg_stb` bits follow the reference strobe, which is never divided.
- R2: `master_vld` is 1 and `master_ch` equals the sampled select value {D,B} (00=A, 01=B, 10=C, 11=D) exactly when `rx_mode` is 6 or 8, there is no error, and `clk_mode` is 0 or 2. Otherwise both outputs are 0.
- R3: With `clk_mode`=1 (per-channel), pin i carries source code i (0..3 = lanes A..D). All pins are enabled, and `reg_stb[i]` follows pin i.
- R4: With `half_rate`=1, a pin or register fed by a recovered lane pulses exactly k times for every 2k consecutive source pulses. With `half_rate`=0 it pulses once per source pulse.
- R5: With `clk_mode`=2 and `rx_mode` 3 or 5 (dual-bonded), pin A takes lane A when B=0 and lane B when B=1. Pin C takes lane C when D=0 and lane D when D=1. Pins B and D are off, registers 0 and 1 follow pin A, and registers 2 and 3 follow pin C.
- R6: With `clk_mode`=2 and `rx_mode` 0, 2, 6 or 8, pins A and C both carry lane {D,B}. Pins B and D are off, and all registers follow that lane.
- R7: `cfg_err` is 1 when `rx_mode` is not one of 0, 2, 3, 5, 6, 8, or when `clk_mode`=3, or when `dec_bypass`=1 with `clk_mode`≠1. The outputs then behave as in R3.
- R8: The select pins are captured on every clock while `rst` is high. Changes after reset release have no effect on sources or on `master_ch`.
- R9: A change of the configuration inputs is seen on `pin_src`, `pin_oe`, `cfg_err` and the master outputs after one clock edge. A source strobe appears on `pin_stb` and `reg_stb` one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset; select pins captured while high |
| ref_stb | input | 1 | Reference character strobe |
| rec_stb | input | 4 | Recovered character strobes, bit i = lane i |
| clk_mode | input | 2 | 0 reference, 1 per-channel, 2 selected, 3 illegal |
| half_rate | input | 1 | Divide recovered strobes by two |
| rx_mode | input | 4 | Receive-mode code |
| dec_bypass | input | 1 | Decoder and elastic buffer bypassed |
| sel_b_pin | input | 1 | Static select level on pin B (low select bit) |
| sel_d_pin | input | 1 | Static select level on pin D (high select bit) |
| pin_stb | output | 4 | Output clock strobes for pins A..D |
| pin_oe | output | 4 | Output enables for pins A..D |
| pin_src | output | 12 | Source code per pin, 3 bits each, pin i at [3i+2:3i] |
| reg_stb | output | 4 | Output-register strobes for lanes A..D |
| cfg_err | output | 1 | Illegal configuration |
| master_vld | output | 1 | Bonding master reported |
| master_ch | output | 2 | Bonding master channel |

## Verification
Two functions can meet in the same cycle: the configuration-error fallback and the half-rate divider. The fallback swaps every pin onto its own lane, and the divider must then halve those lanes rather than the sources the illegal setting asked for. The bench provokes this by pairing illegal settings (bypass with a non-per-channel mode, unlisted receive codes) with the half-rate select. It then counts the strobes on every pin and register over a window whose length is a common multiple of all lane periods, so each lane's count identifies both its source and its divide ratio exactly.

// File: rtl/rxclk_pkg.sv
package rxclk_pkg;
  localparam int NCH   = 4;
  localparam int SRC_W = 3;
  localparam int SEL_W = $clog2(NCH);

  localparam logic [1:0] CM_LOW  = 2'd0;
  localparam logic [1:0] CM_MID  = 2'd1;
  localparam logic [1:0] CM_HIGH = 2'd2;
  localparam logic [1:0] CM_BAD  = 2'd3;

  localparam logic [SRC_W-1:0] SRC_REF = SRC_W'(4);
  localparam logic [SRC_W-1:0] SRC_OFF = SRC_W'(7);
  localparam logic [NCH-1:0]   OE_AC   = NCH'(4'b0101);

  typedef struct packed {
    logic [NCH-1:0][SRC_W-1:0] src;
    logic [NCH-1:0]            oe;
    logic                      half;
    logic                      err;
    logic                      mvld;
    logic [SEL_W-1:0]          mch;
  } route_t;

  function automatic logic rx_mode_ok(input logic [3:0] rm);
    return rm inside {4'd0, 4'd2, 4'd3, 4'd5, 4'd6, 4'd8};
  endfunction

  function automatic logic rx_is_dual(input logic [3:0] rm);
    return rm inside {4'd3, 4'd5};
  endfunction

  function automatic logic rx_is_quad(input logic [3:0] rm);
    return rm inside {4'd6, 4'd8};
  endfunction

  function automatic logic cfg_illegal(input logic [1:0] cm, input logic [3:0] rm,
                                       input logic byp);
    return !rx_mode_ok(rm) || (cm == CM_BAD) || (byp && (cm != CM_MID));
  endfunction

  function automatic route_t plan_route(input logic [1:0] cm, input logic [3:0] rm,
                                        input logic byp, input logic half,
                                        input logic [SEL_W-1:0] sel);
    route_t     r;
    logic       err;
    logic [1:0] eff;
    r   = '0;
    err = cfg_illegal(cm, rm, byp);
    eff = err ? CM_MID : cm;
    for (int i = 0; i < NCH; i++) r.src[i] = SRC_OFF;
    r.half = half;
    r.err  = err;
    case (eff)
      CM_LOW: begin
        r.src[0] = SRC_REF;
        r.src[2] = SRC_REF;
        r.oe     = OE_AC;
      end
      CM_HIGH: begin
        if (rx_is_dual(rm)) begin
          r.src[0] = SRC_W'({1'b0, sel[0]});
          r.src[2] = SRC_W'({1'b1, sel[1]});
        end else begin
          r.src[0] = SRC_W'(sel);
          r.src[2] = SRC_W'(sel);
        end
        r.oe = OE_AC;
      end
      default: begin
        for (int i = 0; i < NCH; i++) r.src[i] = SRC_W'(i);
        r.oe = '1;
      end
    endcase
    r.mvld = !err && rx_is_quad(rm) && (eff != CM_MID);
    r.mch  = r.mvld ? sel : '0;
    return r;
  endfunction
endpackage

// File: rtl/rxclk_sel_latch.sv
module rxclk_sel_latch
  import rxclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_b,
  input  logic             sel_d,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst) sel_q <= {sel_d, sel_b};
  end

  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(sel_q));
endmodule

// File: rtl/rxclk_route_reg.sv
module rxclk_route_reg
  import rxclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       clk_mode,
  input  logic [3:0]       rx_mode,
  input  logic             dec_bypass,
  input  logic             half_rate,
  input  logic [SEL_W-1:0] sel_q,
  output route_t           route_q
);
  route_t route_d;
  route_t route_rst;

  always_comb begin
    route_d   = plan_route(clk_mode, rx_mode, dec_bypass, half_rate, sel_q);
    route_rst = '0;
    for (int i = 0; i < NCH; i++) route_rst.src[i] = SRC_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) route_q <= route_rst;
    else     route_q <= route_d;
  end

  // R7
  err_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    route_q.err |-> (route_q.oe == '1) && !route_q.mvld);
endmodule

// File: rtl/rxclk_pin_gen.sv
module rxclk_pin_gen
  import rxclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src,
  input  logic             oe,
  input  logic             half,
  input  logic             ref_stb,
  input  logic [NCH-1:0]   rec_stb,
  output logic             stb_q
);
  logic from_rec;
  logic raw;
  logic div;
  logic tog;
  logic pass;

  always_comb begin
    from_rec = (src < SRC_W'(NCH));
    raw      = 1'b0;
    if (src == SRC_REF)  raw = ref_stb;
    else if (from_rec)   raw = rec_stb[src[SEL_W-1:0]];
    div  = half && from_rec;
    pass = raw && (!div || tog);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog   <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      if (raw && div) tog <= !tog;
      stb_q <= oe && pass;
    end
  end

  // R4
  half_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (div && $past(div) && $past(div, 2)) |-> !(stb_q && $past(stb_q)));
endmodule

// File: rtl/rxclk_sel_top.sv
module rxclk_sel_top
  import rxclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_stb,
  input  logic [NCH-1:0]       rec_stb,
  input  logic [1:0]           clk_mode,
  input  logic                 half_rate,
  input  logic [3:0]           rx_mode,
  input  logic                 dec_bypass,
  input  logic                 sel_b_pin,
  input  logic                 sel_d_pin,
  output logic [NCH-1:0]       pin_stb,
  output logic [NCH-1:0]       pin_oe,
  output logic [NCH*SRC_W-1:0] pin_src,
  output logic [NCH-1:0]       reg_stb,
  output logic                 cfg_err,
  output logic                 master_vld,
  output logic [SEL_W-1:0]     master_ch
);
  logic [SEL_W-1:0] sel_q;
  route_t           route_q;

  rxclk_sel_latch u_sel (
    .clk(clk), .rst(rst), .sel_b(sel_b_pin), .sel_d(sel_d_pin), .sel_q(sel_q)
  );

  rxclk_route_reg u_route (
    .clk(clk), .rst(rst), .clk_mode(clk_mode), .rx_mode(rx_mode),
    .dec_bypass(dec_bypass), .half_rate(half_rate), .sel_q(sel_q),
    .route_q(route_q)
  );

  for (genvar p = 0; p < NCH; p++) begin : g_pin
    rxclk_pin_gen u_pin (
      .clk(clk), .rst(rst), .src(route_q.src[p]), .oe(route_q.oe[p]),
      .half(route_q.half), .ref_stb(ref_stb), .rec_stb(rec_stb),
      .stb_q(pin_stb[p])
    );
    assign pin_src[p*SRC_W +: SRC_W] = route_q.src[p];
    // registers share their group pin unless every pin carries its own lane
    localparam int GRP = (p / 2) * 2;
    assign reg_stb[p] = route_q.oe[p] ? pin_stb[p] : pin_stb[GRP];
  end

  assign pin_oe     = route_q.oe;
  assign cfg_err    = route_q.err;
  assign master_vld = route_q.mvld;
  assign master_ch  = route_q.mch;

  // R1
  ref_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_src[SRC_W-1:0] == SRC_REF) |->
      (pin_oe == OE_AC) && (pin_src[2*SRC_W +: SRC_W] == SRC_REF));

  // R2
  master_src_chk: assert property (@(posedge clk) disable iff (rst)
    master_vld |-> (pin_src[SRC_W-1:0] == SRC_REF) ||
                   (pin_src[SRC_W-1:0] == SRC_W'(master_ch)));

  // R9
  err_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dec_bypass) && ($past(clk_mode) != CM_MID)) |-> cfg_err);

  // R3
  off_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_stb & ~$past(pin_oe)) == '0);
endmodule

// File: tb/rxclk_sel_top_test.sv
module rxclk_sel_top_test;
  localparam int PERIOD = 10;
  localparam int WIN    = 420;
  localparam int REF_P  = 12;

  logic        clk = 0;
  logic        rst = 1;
  logic        ref_stb = 0;
  logic [3:0]  rec_stb = 0;
  logic [1:0]  clk_mode = 0;
  logic        half_rate = 0;
  logic [3:0]  rx_mode = 0;
  logic        dec_bypass = 0;
  logic        sel_b_pin = 0;
  logic        sel_d_pin = 0;
  logic [3:0]  pin_stb, pin_oe, reg_stb;
  logic [11:0] pin_src;
  logic        cfg_err, master_vld;
  logic [1:0]  master_ch;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit gen_on = 1;
  int cyc = 0;
  int win_left = 0;
  int cnt_pin[4];
  int cnt_reg[4];

  rxclk_sel_top uut (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .rec_stb(rec_stb),
    .clk_mode(clk_mode), .half_rate(half_rate), .rx_mode(rx_mode),
    .dec_bypass(dec_bypass), .sel_b_pin(sel_b_pin), .sel_d_pin(sel_d_pin),
    .pin_stb(pin_stb), .pin_oe(pin_oe), .pin_src(pin_src), .reg_stb(reg_stb),
    .cfg_err(cfg_err), .master_vld(master_vld), .master_ch(master_ch)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int lane_period(int ch);
    case (ch)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  always @(negedge clk) begin
    if (win_left > 0) begin
      for (int i = 0; i < 4; i++) begin
        cnt_pin[i] += int'(pin_stb[i]);
        cnt_reg[i] += int'(reg_stb[i]);
      end
      win_left--;
    end
    cyc++;
    if (gen_on) begin
      ref_stb = (cyc % REF_P) == 0;
      for (int i = 0; i < 4; i++) rec_stb[i] = (cyc % lane_period(i)) == 0;
    end
  end

  // ---- reference model written from the requirements ----
  function automatic bit m_err(int cm, int rm, bit byp);
    bit ok;
    ok = (rm == 0) || (rm == 2) || (rm == 3) || (rm == 5) || (rm == 6) || (rm == 8);
    return !ok || (cm == 3) || (byp && cm != 1);
  endfunction

  function automatic int m_src(int p, int cm, int rm, bit byp, int sel);
    if (m_err(cm, rm, byp) || cm == 1) return p;
    if (p == 1 || p == 3) return 7;
    if (cm == 0) return 4;
    if (rm == 3 || rm == 5) return (p == 0) ? (sel % 2) : (2 + sel / 2);
    return sel;
  endfunction

  function automatic bit m_mvld(int cm, int rm, bit byp);
    return !m_err(cm, rm, byp) && (rm == 6 || rm == 8) && (cm == 0 || cm == 2);
  endfunction

  function automatic int m_reg_src(int ch, int cm, int rm, bit byp, int sel);
    if (m_err(cm, rm, byp) || cm == 1) return ch;
    return m_src((ch < 2) ? 0 : 2, cm, rm, byp, sel);
  endfunction

  function automatic int m_count(int src, bit half);
    if (src == 7) return 0;
    if (src == 4) return WIN / REF_P;
    return (WIN / lane_period(src)) / (half ? 2 : 1);
  endfunction

  function automatic string m_tag(int cm, int rm, bit byp);
    if (m_err(cm, rm, byp)) return "R7";
    if (cm == 0) return "R1";
    if (cm == 1) return "R3";
    if (rm == 3 || rm == 5) return "R5";
    return "R6";
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(int sel);
    @(negedge clk);
    rst = 1;
    sel_b_pin = sel[0];
    sel_d_pin = sel[1];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic apply_cfg(int cm, int rm, bit byp, bit half);
    @(negedge clk);
    clk_mode = 2'(cm);
    rx_mode = 4'(rm);
    dec_bypass = byp;
    half_rate = half;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_static(int cm, int rm, bit byp, int sel);
    string t;
    int es;
    t = m_tag(cm, rm, byp);
    for (int p = 0; p < 4; p++) begin
      es = m_src(p, cm, rm, byp, sel);
      chk(int'(pin_src[3*p +: 3]) == es, t, $sformatf("pin%0d src", p),
          int'(pin_src[3*p +: 3]), es);
      chk(pin_oe[p] == (es != 7), t, $sformatf("pin%0d oe", p),
          int'(pin_oe[p]), int'(es != 7));
    end
    chk(cfg_err == m_err(cm, rm, byp), "R7", "cfg_err", int'(cfg_err),
        int'(m_err(cm, rm, byp)));
    chk(master_vld == m_mvld(cm, rm, byp), "R2", "master_vld", int'(master_vld),
        int'(m_mvld(cm, rm, byp)));
    chk(int'(master_ch) == (m_mvld(cm, rm, byp) ? sel : 0), "R2", "master_ch",
        int'(master_ch), m_mvld(cm, rm, byp) ? sel : 0);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk(pin_oe == 4'b0000, "R9", "reset oe", int'(pin_oe), 0);
    chk(pin_stb == 4'b0000 && reg_stb == 4'b0000, "R9", "reset strobes",
        int'(pin_stb), 0);
    chk(cfg_err == 0 && master_vld == 0, "R9", "reset flags", int'(cfg_err), 0);
    rst = 0;
  endtask

  task automatic test_sweep();
    int rms[10] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 15};
    for (int sel = 0; sel < 4; sel++) begin
      do_reset(sel);
      for (int cm = 0; cm < 4; cm++)
        for (int k = 0; k < 10; k++)
          for (int byp = 0; byp < 2; byp++) begin
            apply_cfg(cm, rms[k], bit'(byp), 1'b0);
            check_static(cm, rms[k], bit'(byp), sel);
          end
    end
  endtask

  task automatic count_case(int cm, int rm, bit byp, int sel, bit half);
    string t;
    int es;
    do_reset(sel);
    apply_cfg(cm, rm, byp, half);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      cnt_pin[i] = 0;
      cnt_reg[i] = 0;
    end
    win_left = WIN;
    wait (win_left == 0);
    t = half ? "R4" : m_tag(cm, rm, byp);
    for (int p = 0; p < 4; p++) begin
      es = m_count(m_src(p, cm, rm, byp, sel), half);
      chk(cnt_pin[p] == es, t, $sformatf("pin%0d strobe count cm%0d rm%0d", p, cm, rm),
          cnt_pin[p], es);
      es = m_count(m_reg_src(p, cm, rm, byp, sel), half);
      chk(cnt_reg[p] == es, t, $sformatf("reg%0d strobe count cm%0d rm%0d", p, cm, rm),
          cnt_reg[p], es);
    end
  endtask

  task automatic test_counts();
    for (int h = 0; h < 2; h++) begin
      count_case(0, 6, 0, 2, bit'(h));  // R1 reference
      count_case(1, 0, 0, 0, bit'(h));  // R3 per-channel
      count_case(2, 3, 0, 1, bit'(h));  // R5 lanes B and C
      count_case(2, 5, 0, 2, bit'(h));  // R5 lanes A and D
      count_case(2, 6, 0, 3, bit'(h));  // R6 quad
      count_case(2, 0, 0, 1, bit'(h));  // R6 independent
      count_case(0, 2, 1, 1, bit'(h));  // R7 bypass fallback with divider
      count_case(2, 7, 0, 3, bit'(h));  // R7 unlisted code with divider
    end
  endtask

  task automatic test_sel_frozen();
    do_reset(2);
    apply_cfg(2, 6, 0, 0);
    sel_b_pin = 1;
    sel_d_pin = 0;
    repeat (4) @(negedge clk);
    chk(int'(pin_src[2:0]) == 2, "R8", "pin A src after select change",
        int'(pin_src[2:0]), 2);
    chk(int'(master_ch) == 2, "R8", "master after select change", int'(master_ch), 2);
  endtask

  task automatic test_latency();
    do_reset(0);
    apply_cfg(0, 0, 0, 0);
    @(negedge clk);
    dec_bypass = 1;
    chk(cfg_err == 0, "R9", "cfg_err before edge", int'(cfg_err), 0);
    @(negedge clk);
    chk(cfg_err == 1, "R9", "cfg_err one edge later", int'(cfg_err), 1);
    dec_bypass = 0;
    clk_mode = 1;
    @(negedge clk);
    gen_on = 0;
    ref_stb = 0;
    rec_stb = 0;
    repeat (2) @(negedge clk);
    rec_stb = 4'b0100;
    chk(pin_stb == 4'b0000, "R9", "strobe before edge", int'(pin_stb), 0);
    @(negedge clk);
    rec_stb = 4'b0000;
    chk(pin_stb == 4'b0100, "R9", "pin strobe one edge later", int'(pin_stb), 4);
    chk(reg_stb == 4'b0100, "R9", "reg strobe one edge later", int'(reg_stb), 4);
    @(negedge clk);
    chk(pin_stb == 4'b0000, "R9", "strobe single cycle", int'(pin_stb), 0);
    gen_on = 1;
  endtask

  initial begin
    test_reset_state();
    test_latency();
    test_sel_frozen();
    test_sweep();
    test_counts();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule